// File: doc/BRIEF.md
# Descriptor Ring Pointer Manager

This block tracks the current position in two circular descriptor rings kept in host memory: one serving transmit, one serving receive. Software programs a base address and an entry count for each ring through a small register-write port. A start strobe loads the programmed settings and points both rings at their first entry. After that, the DMA engine pulses a per-ring advance strobe each time it retires a descriptor. Each index steps forward and returns to zero after the last entry. The block always presents the byte address of the current descriptor for both rings.

Each entry takes 8 bytes, so the current address is the ring base plus eight times the index. A start strobe issued after a stop is a restart. It reloads both rings to their bases in the same way a first start does, and it picks up any settings programmed since the last start. A suspend flag freezes both positions. When the flag drops, the rings carry on from exactly where they stood, with no reload.

Top module: `desc_ring_ptr`

## Requirements
- R1: After reset both indices are 0, both addresses are 0, both misalign flags are 0, the block is stopped, and each ring's programmed length is 128 with programmed base 0.
- R2: A base write (wr_sel_i bit 0 = 0; bit 1 selects ring, 0 = transmit, 1 = receive) stores the data with bits 2:0 cleared. The ring's misalign_o bit (bit 0 transmit, bit 1 receive) is set if the written bits 2:0 were non-zero and cleared otherwise.
- R3: A length write (wr_sel_i bit 0 = 1) stores the value if it is a power of two from 1 to 128. Any other value, including 0, stores 128.
- R4: Each ring's address output equals its active base plus 8 times its index.
- R5: While running, an advance on a ring raises its index by one. From length minus one it wraps to 0, so a length of 1 keeps the index at 0.
- R6: A start strobe sets both indices to 0 and latches the programmed bases and lengths as the active ones. This applies on a first start, on a restart after a stop, and while suspended.
- R7: While suspend_i is high, advances are ignored. After it drops, the rings continue from the held positions.
- R8: While stopped, advances are ignored. A stop strobe blocks an advance in the same cycle, and a start strobe in the same cycle as an advance yields index 0.
- R9: An advance on one ring never moves the other ring's index.
- R10: Base and length writes do not change the address outputs until the next start strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write enable |
| wr_sel_i | input | 2 | Bit 1: ring (0 transmit, 1 receive); bit 0: field (0 base, 1 length) |
| wr_data_i | input | 32 | Write data |
| start_i | input | 1 | Init/restart strobe |
| stop_i | input | 1 | Stop strobe |
| suspend_i | input | 1 | Suspend flag (level) |
| adv_i | input | 2 | Advance strobes, bit 0 transmit, bit 1 receive |
| tx_addr_o | output | 32 | Current transmit descriptor address |
| rx_addr_o | output | 32 | Current receive descriptor address |
| tx_idx_o | output | 7 | Current transmit index |
| rx_idx_o | output | 7 | Current receive index |
| misalign_o | output | 2 | Last base write per ring had non-zero low bits |

## Verification
The advance function is exercised with single-ring bursts, simultaneous advances on both rings, and advances that collide with a start, a stop or a suspend. These patterns separate correct wrap and independence from off-by-one wrap points and from cross-ring coupling. Lengths of 1, 2 and 4, plus the illegal values 0, 3, 6 and 200, are each followed by enough advances to expose where the index wraps. This distinguishes saturation to 128 from accepting the raw value. Bases are rewritten while the block runs and while it is stopped, which shows whether the address moves only at start.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;
  localparam int RING_TX = 0;
  localparam int RING_RX = 1;
  localparam int N_RINGS = 2;

  typedef enum logic {
    FLD_BASE = 1'b0,
    FLD_LEN  = 1'b1
  } field_e;

  typedef enum logic {
    ST_STOP = 1'b0,
    ST_RUN  = 1'b1
  } run_e;
endpackage

// File: rtl/desc_ring_cfg.sv
module desc_ring_cfg #(
  parameter int ADDR_W      = 32,
  parameter int MAX_ENTRIES = 128,
  parameter int ENTRY_BYTES = 8,
  localparam int LEN_W      = $clog2(MAX_ENTRIES) + 1,
  localparam int OFS_W      = $clog2(ENTRY_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_we_i,
  input  logic              len_we_i,
  input  logic [ADDR_W-1:0] data_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              misalign_o
);
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  len_q;
  logic              mis_q;
  logic              len_ok;

  // legal: non-zero power of two not above MAX_ENTRIES
  always_comb begin
    len_ok = (data_i != '0) &&
             (data_i <= ADDR_W'(MAX_ENTRIES)) &&
             ((data_i & (data_i - ADDR_W'(1))) == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      len_q  <= LEN_W'(MAX_ENTRIES);
      mis_q  <= 1'b0;
    end else begin
      if (base_we_i) begin
        base_q <= {data_i[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
        mis_q  <= |data_i[OFS_W-1:0];
      end
      if (len_we_i) begin
        len_q <= len_ok ? data_i[LEN_W-1:0] : LEN_W'(MAX_ENTRIES);
      end
    end
  end

  assign base_o     = base_q;
  assign len_o      = len_q;
  assign misalign_o = mis_q;
endmodule

// File: rtl/desc_ring_idx.sv
module desc_ring_idx #(
  parameter int ADDR_W      = 32,
  parameter int MAX_ENTRIES = 128,
  parameter int ENTRY_BYTES = 8,
  localparam int IDX_W      = $clog2(MAX_ENTRIES),
  localparam int LEN_W      = IDX_W + 1,
  localparam int OFS_W      = $clog2(ENTRY_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [IDX_W-1:0]  last_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  last_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LEN_W-1:0]  len_m1;

  assign len_m1 = len_i - LEN_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      last_q <= IDX_W'(MAX_ENTRIES - 1);
      idx_q  <= '0;
    end else if (load_i) begin
      base_q <= base_i;
      last_q <= len_m1[IDX_W-1:0];
      idx_q  <= '0;
    end else if (adv_i) begin
      idx_q <= (idx_q == last_q) ? '0 : idx_q + IDX_W'(1);
    end
  end

  assign idx_o  = idx_q;
  assign last_o = last_q;
  assign addr_o = base_q + ADDR_W'({idx_q, {OFS_W{1'b0}}});
endmodule

// File: rtl/desc_ring_ctrl.sv
module desc_ring_ctrl
  import desc_ring_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  input  logic suspend_i,
  output logic load_o,
  output logic step_o,
  output logic run_o
);
  run_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= ST_STOP;
    else if (start_i) state_q <= ST_RUN;
    else if (stop_i)  state_q <= ST_STOP;
  end

  assign load_o = start_i;
  // start and stop both outrank an advance
  assign step_o = (state_q == ST_RUN) && !suspend_i && !start_i && !stop_i;
  assign run_o  = (state_q == ST_RUN);
endmodule

// File: rtl/desc_ring_ptr.sv
module desc_ring_ptr
  import desc_ring_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int MAX_ENTRIES = 128,
  parameter int ENTRY_BYTES = 8,
  localparam int IDX_W      = $clog2(MAX_ENTRIES),
  localparam int LEN_W      = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              suspend_i,
  input  logic [1:0]        adv_i,
  output logic [ADDR_W-1:0] tx_addr_o,
  output logic [ADDR_W-1:0] rx_addr_o,
  output logic [IDX_W-1:0]  tx_idx_o,
  output logic [IDX_W-1:0]  rx_idx_o,
  output logic [1:0]        misalign_o
);
  logic                           load;
  logic                           step;
  logic                           run;
  logic [N_RINGS-1:0][ADDR_W-1:0] ring_addr;
  logic [N_RINGS-1:0][IDX_W-1:0]  ring_idx;
  logic [N_RINGS-1:0][IDX_W-1:0]  ring_last;

  desc_ring_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .suspend_i(suspend_i),
    .load_o   (load),
    .step_o   (step),
    .run_o    (run)
  );

  for (genvar r = 0; r < N_RINGS; r++) begin : g_ring
    logic              base_we;
    logic              len_we;
    logic [ADDR_W-1:0] prog_base;
    logic [LEN_W-1:0]  prog_len;

    assign base_we = wr_en_i && (wr_sel_i[1] == 1'(r)) && (wr_sel_i[0] == FLD_BASE);
    assign len_we  = wr_en_i && (wr_sel_i[1] == 1'(r)) && (wr_sel_i[0] == FLD_LEN);

    desc_ring_cfg #(
      .ADDR_W     (ADDR_W),
      .MAX_ENTRIES(MAX_ENTRIES),
      .ENTRY_BYTES(ENTRY_BYTES)
    ) u_cfg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .base_we_i (base_we),
      .len_we_i  (len_we),
      .data_i    (wr_data_i),
      .base_o    (prog_base),
      .len_o     (prog_len),
      .misalign_o(misalign_o[r])
    );

    desc_ring_idx #(
      .ADDR_W     (ADDR_W),
      .MAX_ENTRIES(MAX_ENTRIES),
      .ENTRY_BYTES(ENTRY_BYTES)
    ) u_idx (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .load_i(load),
      .adv_i (step && adv_i[r]),
      .base_i(prog_base),
      .len_i (prog_len),
      .idx_o (ring_idx[r]),
      .last_o(ring_last[r]),
      .addr_o(ring_addr[r])
    );
  end

  assign tx_addr_o = ring_addr[RING_TX];
  assign rx_addr_o = ring_addr[RING_RX];
  assign tx_idx_o  = ring_idx[RING_TX];
  assign rx_idx_o  = ring_idx[RING_RX];
endmodule

// File: rtl/desc_ring_ptr_chk.sv
module desc_ring_ptr_chk #(
  parameter int ADDR_W      = 32,
  parameter int MAX_ENTRIES = 128,
  parameter int ENTRY_BYTES = 8,
  localparam int IDX_W      = $clog2(MAX_ENTRIES),
  localparam int OFS_W      = $clog2(ENTRY_BYTES)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  start_i,
  input logic                  stop_i,
  input logic                  suspend_i,
  input logic [1:0]            adv_i,
  input logic                  run_i,
  input logic [1:0][IDX_W-1:0] last_i,
  input logic [ADDR_W-1:0]     tx_addr_o,
  input logic [ADDR_W-1:0]     rx_addr_o,
  input logic [IDX_W-1:0]      tx_idx_o,
  input logic [IDX_W-1:0]      rx_idx_o
);
  logic live;
  assign live = run_i && !suspend_i && !start_i && !stop_i;

  a_r6_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (tx_idx_o == '0) && (rx_idx_o == '0));

  a_r7_suspend_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (suspend_i && !start_i) |=> $stable(tx_idx_o) && $stable(rx_idx_o));

  a_r8_stopped_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!run_i || stop_i) && !start_i) |=> $stable(tx_idx_o) && $stable(rx_idx_o));

  a_r5_tx_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && adv_i[0] && (tx_idx_o == last_i[0])) |=> (tx_idx_o == '0));

  a_r5_rx_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && adv_i[1] && (rx_idx_o == last_i[1])) |=> (rx_idx_o == '0));

  a_r5_tx_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && adv_i[0] && (tx_idx_o != last_i[0])) |=>
      (tx_idx_o == IDX_W'($past(tx_idx_o) + IDX_W'(1))));

  a_r9_rx_indep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !adv_i[1]) |=> $stable(rx_idx_o));

  a_r4_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_addr_o[OFS_W-1:0] == '0) && (rx_addr_o[OFS_W-1:0] == '0));
endmodule

bind desc_ring_ptr desc_ring_ptr_chk #(
  .ADDR_W     (ADDR_W),
  .MAX_ENTRIES(MAX_ENTRIES),
  .ENTRY_BYTES(ENTRY_BYTES)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .stop_i   (stop_i),
  .suspend_i(suspend_i),
  .adv_i    (adv_i),
  .run_i    (run),
  .last_i   (ring_last),
  .tx_addr_o(tx_addr_o),
  .rx_addr_o(rx_addr_o),
  .tx_idx_o (tx_idx_o),
  .rx_idx_o (rx_idx_o)
);

// File: tb/desc_ring_ptr_tb.sv
module desc_ring_ptr_tb;
  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        start = 1'b0, stop = 1'b0, susp = 1'b0;
  logic [1:0]  adv = '0;
  logic [31:0] tx_addr, rx_addr;
  logic [6:0]  tx_idx, rx_idx;
  logic [1:0]  mis;

  desc_ring_ptr u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .start_i(start), .stop_i(stop), .suspend_i(susp),
    .adv_i(adv), .tx_addr_o(tx_addr), .rx_addr_o(rx_addr),
    .tx_idx_o(tx_idx), .rx_idx_o(rx_idx), .misalign_o(mis)
  );

  always #(CLK_NS/2) clk = ~clk;

  typedef struct {
    string       tag;
    logic [31:0] txa, rxa;
    logic [6:0]  txi, rxi;
    logic [1:0]  mis;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // bench reference state
  logic [31:0] p_base[2], a_base[2];
  int          p_len[2], a_len[2], idx[2];
  logic [1:0]  m_mis;
  bit          running;

  task automatic push(input string tag);
    item_t it;
    it.tag = tag;
    it.txi = 7'(idx[0]);
    it.rxi = 7'(idx[1]);
    it.txa = a_base[0] + 32'(idx[0] * 8);
    it.rxa = a_base[1] + 32'(idx[1] * 8);
    it.mis = m_mis;
    q.push_back(it);
  endtask

  task automatic cyc(input logic we, input logic [1:0] sel, input logic [31:0] d,
                     input logic st, input logic sp, input logic su,
                     input logic [1:0] av, input string tag);
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_data = d;
    start = st; stop = sp; susp = su; adv = av;
    @(posedge clk);
    if (st) begin
      running = 1;
      for (int r = 0; r < 2; r++) begin
        a_base[r] = p_base[r]; a_len[r] = p_len[r]; idx[r] = 0;
      end
    end else if (sp) begin
      running = 0;
    end else if (running && !su) begin
      for (int r = 0; r < 2; r++)
        if (av[r]) idx[r] = (idx[r] == a_len[r] - 1) ? 0 : idx[r] + 1;
    end
    if (we) begin
      if (sel[0] == 1'b0) begin
        p_base[sel[1]] = {d[31:3], 3'b000};
        m_mis[sel[1]]  = |d[2:0];
      end else begin
        p_len[sel[1]] = (d != 0 && d <= 128 && (d & (d - 1)) == 0) ? int'(d) : 128;
      end
    end
    push(tag);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d, input string tag);
    cyc(1'b1, sel, d, 1'b0, 1'b0, 1'b0, 2'b00, tag);
  endtask
  task automatic go(input string tag);
    cyc(1'b0, 2'b00, 32'h0, 1'b1, 1'b0, 1'b0, 2'b00, tag);
  endtask
  task automatic step(input logic [1:0] av, input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'b00, 32'h0, 1'b0, 1'b0, 1'b0, av, tag);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (tx_addr !== it.txa || rx_addr !== it.rxa || tx_idx !== it.txi ||
          rx_idx !== it.rxi || mis !== it.mis) begin
        errors++;
        $display("FAIL %s: got txa=%h rxa=%h txi=%0d rxi=%0d mis=%b exp txa=%h rxa=%h txi=%0d rxi=%0d mis=%b",
                 it.tag, tx_addr, rx_addr, tx_idx, rx_idx, mis,
                 it.txa, it.rxa, it.txi, it.rxi, it.mis);
      end
    end
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 2; r++) begin
      p_base[r] = 0; a_base[r] = 0; p_len[r] = 128; a_len[r] = 128; idx[r] = 0;
    end
    m_mis = 0; running = 0;
    repeat (2) @(posedge clk);
    push("R1 reset state");
    @(negedge clk);
    rst_n = 1'b1;

    step(2'b11, 2, "R8 advance while stopped ignored");
    wr(2'b00, 32'h0000_1000, "R2 aligned tx base");
    wr(2'b10, 32'h0000_2003, "R2 misaligned rx base");
    wr(2'b01, 32'd4, "R10 tx len write no effect before start");
    wr(2'b11, 32'd3, "R3 rx len 3 saturates");
    go("R6 start loads bases");
    step(2'b01, 3, "R4 R5 tx advance");
    step(2'b01, 1, "R5 tx wrap at len 4");
    step(2'b10, 127, "R9 rx only advance");
    step(2'b10, 1, "R3 rx wraps at 128");
    step(2'b11, 1, "R9 both advance");
    cyc(1'b0, 2'b00, 32'h0, 1'b0, 1'b0, 1'b1, 2'b11, "R7 suspended advance ignored");
    cyc(1'b0, 2'b00, 32'h0, 1'b0, 1'b0, 1'b1, 2'b01, "R7 suspended advance ignored");
    step(2'b11, 1, "R7 resume continues");
    wr(2'b00, 32'h0000_3000, "R10 base write while running");
    wr(2'b10, 32'h0000_2008, "R2 aligned write clears flag");
    step(2'b01, 1, "R10 old base still active");
    cyc(1'b0, 2'b00, 32'h0, 1'b0, 1'b1, 1'b0, 2'b11, "R8 stop blocks advance");
    step(2'b11, 2, "R8 stopped hold");
    go("R6 restart reloads new bases");
    step(2'b11, 2, "R4 after restart");
    cyc(1'b0, 2'b00, 32'h0, 1'b1, 1'b0, 1'b0, 2'b11, "R8 start beats advance");
    step(2'b01, 1, "R5 advance after start");
    cyc(1'b0, 2'b00, 32'h0, 1'b0, 1'b0, 1'b1, 2'b01, "R7 suspend");
    cyc(1'b0, 2'b00, 32'h0, 1'b1, 1'b0, 1'b1, 2'b00, "R6 start while suspended");
    wr(2'b01, 32'd1, "R3 tx len 1");
    wr(2'b11, 32'd2, "R3 rx len 2");
    go("R6 start with len 1 and 2");
    step(2'b11, 3, "R5 len 1 stays 0 len 2 wraps");
    wr(2'b01, 32'd6, "R3 tx len 6 saturates");
    wr(2'b11, 32'd0, "R3 rx len 0 saturates");
    go("R6 start");
    step(2'b11, 7, "R3 no wrap at 6 or 0");
    wr(2'b01, 32'd200, "R3 tx len 200 saturates");
    wr(2'b11, 32'd128, "R3 rx len 128 accepted");
    go("R6 start");
    step(2'b01, 130, "R3 tx wraps at 128");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule